// File: doc/BRIEF.md
# Serial Interrupt Frame Agent

This block is the peripheral end of a single-wire serial interrupt line. The line is open-drain and is clocked by the bus clock. Seven interrupt sources feed the block: two keyboard/mouse-style requests from the first mailbox channel, and a system-management request plus four numbered interrupts from the remaining channels. The block does not use a dedicated wire for each interrupt. It watches the shared line for a start frame and then walks a train of three-clock time slots. It pulls the line low in the slot that belongs to each request that is active at that moment.

The host ends every frame with a short low pulse, and the length of that pulse selects how the next frame begins. In continuous mode only the host opens a frame. In quiet mode the agent may open a frame itself when a request newly appears: it pulls the line low for one clock and the host stretches that pulse into a full start frame. The pad is modelled as an output-enable and an output value, with the sensed line level brought back on a separate input.

Top module: `sirq_agent`

## Requirements
- R1: After reset the line is released (`sirq_oe` = 0) and the agent is in continuous mode.
- R2: When the sensed line returns high after a low run of 4 to 8 clocks while the agent is idle, a frame begins. The sample phase of slot 0 is the clock right after the first high clock, and slot k's sample phase comes 3k clocks later.
- R3: A low run shorter than 4 or longer than 8 clocks while idle starts no frame, and the line stays released.
- R4: Slot map: irq1 uses slot 1, smi uses slot 2, irq6 uses slot 6, irq9, irq10 and irq11 use slots 9, 10 and 11, and irq12 uses slot 12. Sixteen slots (0 to 15) make up a frame, and every other slot stays released.
- R5: In the slot of an active request the agent drives low in the sample clock, drives high in the recovery clock and releases in the turnaround clock. It releases all three clocks of an inactive slot.
- R6: Each request is read as a level at the clock edge that opens its slot's sample phase. A request dropped before its slot is not sent in that frame, and a request raised during the frame but before its slot is sent.
- R7: After slot 15 the agent waits for the stop pulse. A low run of 2 clocks selects quiet mode, a run of 3 selects continuous mode, and the agent then returns to idle.
- R8: In quiet mode, a request that rises while the agent is idle and the line is high makes the agent drive the line low for exactly one clock. That clock is the second clock after the request rises.
- R9: In continuous mode the agent never drives the line outside a frame, even when a request rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq1_req | input | 1 | Channel-1 request sent in slot 1 |
| irq12_req | input | 1 | Channel-1 request sent in slot 12 |
| smi_req | input | 1 | System-management request sent in slot 2 |
| irq6_req | input | 1 | Request sent in slot 6 |
| irq9_req | input | 1 | Request sent in slot 9 |
| irq10_req | input | 1 | Request sent in slot 10 |
| irq11_req | input | 1 | Request sent in slot 11 |
| sirq_in | input | 1 | Sensed level of the shared line |
| sirq_oe | output | 1 | Agent drives the line when high |
| sirq_out | output | 1 | Level driven while `sirq_oe` is high |

## Verification
The hardest case to reach is the agent opening a frame by itself. That needs a stop pulse of exactly two clocks to select quiet mode, then a frame that clears any leftover pending request, and only then a fresh request edge while the line is idle. The bench runs that exact sequence and checks that the single low clock lands two clocks after the edge. The level-sampling rule is the other hard case. It needs request changes in the middle of a frame, so a parallel branch drops one request and raises another at a counted clock inside the slot train while the capture runs.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_STOP = 2'd2
  } sirq_state_e;

  localparam logic [1:0] PH_SAMPLE  = 2'd0;
  localparam logic [1:0] PH_RECOVER = 2'd1;
  localparam logic [1:0] PH_TURN    = 2'd2;

endpackage

// File: rtl/sirq_req_map.sv
module sirq_req_map #(
  parameter int NUM_SRC   = 7,
  parameter int NUM_SLOTS = 16,
  parameter int SRC_SLOT [NUM_SRC] = '{1, 2, 6, 9, 10, 11, 12}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_req,
  output logic [NUM_SLOTS-1:0] slot_req,
  output logic                 req_rise
);

  logic [NUM_SRC-1:0] src_prev_q;

  always_comb begin
    slot_req = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      slot_req[SRC_SLOT[i]] = slot_req[SRC_SLOT[i]] | src_req[i];
    end
  end

  assign req_rise = |(src_req & ~src_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev_q <= '0;
    else        src_prev_q <= src_req;
  end

endmodule

// File: rtl/sirq_low_timer.sv
module sirq_low_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic [CNT_W-1:0] run_len,
  output logic             run_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (line_in)            cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run_len = cnt_q;
  assign run_end = line_in & (cnt_q != '0);

endmodule

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int CNT_W      = 5,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  input  logic [CNT_W-1:0]     run_len,
  input  logic                 run_end,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic                 req_rise,
  output logic                 drv_oe,
  output logic                 drv_val,
  output sirq_state_e          state,
  output logic [1:0]           phase,
  output logic [SLOT_W-1:0]    slot,
  output logic                 quiet
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  sirq_state_e       st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_inc;
  logic              hold_q, hold_d;
  logic              quiet_q, quiet_d;
  logic              pend_q, pend_d;
  logic              oe_q, oe_d;
  logic              val_q, val_d;
  logic              start_ok;

  assign slot_inc = slot_q + 1'b1;
  assign start_ok = run_end && (run_len >= CNT_W'(START_MIN))
                            && (run_len <= CNT_W'(START_MAX));

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    slot_d  = slot_q;
    hold_d  = hold_q;
    quiet_d = quiet_q;
    pend_d  = pend_q | req_rise;
    oe_d    = 1'b0;
    val_d   = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d   = ST_SLOT;
          ph_d   = PH_SAMPLE;
          slot_d = '0;
          hold_d = slot_req[0];
          oe_d   = slot_req[0];
          val_d  = 1'b0;
          pend_d = req_rise;
        end else if (quiet_q && pend_q && line_in && (run_len == '0) && !oe_q) begin
          oe_d  = 1'b1;
          val_d = 1'b0;
        end
      end
      ST_SLOT: begin
        unique case (ph_q)
          PH_SAMPLE: begin
            ph_d = PH_RECOVER;
            oe_d = hold_q;
          end
          PH_RECOVER: ph_d = PH_TURN;
          default: begin
            if (slot_q == LAST_SLOT) begin
              st_d = ST_STOP;
            end else begin
              slot_d = slot_inc;
              ph_d   = PH_SAMPLE;
              hold_d = slot_req[slot_inc];
              oe_d   = slot_req[slot_inc];
              val_d  = 1'b0;
            end
          end
        endcase
      end
      default: begin
        if (run_end) begin
          st_d = ST_IDLE;
          if (run_len == CNT_W'(STOP_QUIET))     quiet_d = 1'b1;
          else if (run_len == CNT_W'(STOP_CONT)) quiet_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_SAMPLE;
      slot_q  <= '0;
      hold_q  <= 1'b0;
      quiet_q <= 1'b0;
      pend_q  <= 1'b0;
      oe_q    <= 1'b0;
      val_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      slot_q  <= slot_d;
      hold_q  <= hold_d;
      quiet_q <= quiet_d;
      pend_q  <= pend_d;
      oe_q    <= oe_d;
      val_q   <= val_d;
    end
  end

  assign drv_oe  = oe_q;
  assign drv_val = val_q;
  assign state   = st_q;
  assign phase   = ph_q;
  assign slot    = slot_q;
  assign quiet   = quiet_q;

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  localparam int CNT_W     = $clog2(START_MAX + 1) + 1,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int NUM_SRC   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq1_req,
  input  logic irq12_req,
  input  logic smi_req,
  input  logic irq6_req,
  input  logic irq9_req,
  input  logic irq10_req,
  input  logic irq11_req,
  input  logic sirq_in,
  output logic sirq_oe,
  output logic sirq_out
);

  logic [1:0]           rst_sync_q;
  logic                 rst_q;
  logic [NUM_SRC-1:0]   src_req;
  logic [NUM_SLOTS-1:0] slot_req;
  logic                 req_rise;
  logic [CNT_W-1:0]     run_len;
  logic                 run_end;
  sirq_state_e          st_w;
  logic [1:0]           ph_w;
  logic [SLOT_W-1:0]    slot_w;
  logic                 quiet_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign src_req = {irq12_req, irq11_req, irq10_req, irq9_req,
                    irq6_req, smi_req, irq1_req};

  sirq_req_map #(
    .NUM_SRC   (NUM_SRC),
    .NUM_SLOTS (NUM_SLOTS),
    .SRC_SLOT  ('{1, 2, 6, 9, 10, 11, 12})
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_q),
    .src_req  (src_req),
    .slot_req (slot_req),
    .req_rise (req_rise)
  );

  sirq_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q),
    .line_in (sirq_in),
    .run_len (run_len),
    .run_end (run_end)
  );

  sirq_frame_fsm #(
    .NUM_SLOTS  (NUM_SLOTS),
    .START_MIN  (START_MIN),
    .START_MAX  (START_MAX),
    .STOP_QUIET (STOP_QUIET),
    .STOP_CONT  (STOP_CONT),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_q),
    .line_in  (sirq_in),
    .run_len  (run_len),
    .run_end  (run_end),
    .slot_req (slot_req),
    .req_rise (req_rise),
    .drv_oe   (sirq_oe),
    .drv_val  (sirq_out),
    .state    (st_w),
    .phase    (ph_w),
    .slot     (slot_w),
    .quiet    (quiet_w)
  );

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk
  import sirq_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_q,
  input sirq_state_e       st_w,
  input logic [1:0]        ph_w,
  input logic [SLOT_W-1:0] slot_w,
  input logic              quiet_w,
  input logic              sirq_oe,
  input logic              sirq_out
);

  p_idle_quiet_cont_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_IDLE && !quiet_w) |-> !sirq_oe);

  p_pulse_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_IDLE && sirq_oe) |=> !sirq_oe);

  p_sample_low_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_SLOT && ph_w == PH_SAMPLE && sirq_oe) |-> !sirq_out);

  p_recover_high_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_SLOT && ph_w == PH_RECOVER && sirq_oe) |-> sirq_out);

  p_turn_release_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_SLOT && ph_w == PH_TURN) |-> !sirq_oe);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_STOP) |-> !sirq_oe);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (st_w == ST_SLOT && ph_w == PH_TURN && slot_w != '1)
      |=> (st_w == ST_SLOT && ph_w == PH_SAMPLE && slot_w == $past(slot_w) + 1'b1));

endmodule

bind sirq_agent sirq_agent_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .st_w     (st_w),
  .ph_w     (ph_w),
  .slot_w   (slot_w),
  .quiet_w  (quiet_w),
  .sirq_oe  (sirq_oe),
  .sirq_out (sirq_out)
);

// File: tb/tb_sirq_agent.sv
module tb_sirq_agent;

  logic       clk;
  logic       rst_n;
  logic [6:0] req;
  logic       host_low;
  logic       sirq_oe;
  logic       sirq_out;
  logic       line;
  int         errors;
  int         checks;
  bit         cap_line [48];
  bit         cap_oe [48];

  assign line = host_low ? 1'b0 : (sirq_oe ? sirq_out : 1'b1);

  sirq_agent dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq1_req  (req[0]),
    .irq12_req (req[6]),
    .smi_req   (req[1]),
    .irq6_req  (req[2]),
    .irq9_req  (req[3]),
    .irq10_req (req[4]),
    .irq11_req (req[5]),
    .sirq_in   (line),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // req bits: 0 irq1, 1 smi, 2 irq6, 3 irq9, 4 irq10, 5 irq11, 6 irq12
  // fields: [26:20] requests, [19:16] start low clocks, [15:0] expected slot mask
  localparam logic [26:0] VEC [8] = '{
    {7'h01, 4'd4, 16'h0002},
    {7'h40, 4'd8, 16'h1000},
    {7'h02, 4'd5, 16'h0004},
    {7'h3C, 4'd6, 16'h0E40},
    {7'h7F, 4'd4, 16'h1E46},
    {7'h00, 4'd7, 16'h0000},
    {7'h7F, 4'd3, 16'h0000},
    {7'h7F, 4'd9, 16'h0000}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic host_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic capture();
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      cap_line[i] = line;
      cap_oe[i]   = sirq_oe;
    end
  endtask

  task automatic judge(input logic [15:0] exp_mask, input string tag);
    logic [15:0] obs;
    logic [15:0] oe_s;
    logic [15:0] rec_bad;
    logic [15:0] turn_bad;
    for (int k = 0; k < 16; k++) begin
      obs[k]      = ~cap_line[3*k];
      oe_s[k]     = cap_oe[3*k];
      rec_bad[k]  = (cap_oe[3*k+1] != exp_mask[k]) || !cap_line[3*k+1];
      turn_bad[k] = cap_oe[3*k+2];
    end
    check(obs == exp_mask, tag, "slot low mask", {16'h0, obs}, {16'h0, exp_mask});
    check(oe_s == exp_mask, "R5", "sample-phase drive mask", {16'h0, oe_s}, {16'h0, exp_mask});
    check(rec_bad == 16'h0, "R5", "recovery drive-high", {16'h0, rec_bad}, 32'h0);
    check(turn_bad == 16'h0, "R5", "turnaround release", {16'h0, turn_bad}, 32'h0);
  endtask

  task automatic frame(input int start_len, input int stop_len,
                       input logic [15:0] exp_mask, input string tag);
    host_pulse(start_len);
    capture();
    judge(exp_mask, tag);
    host_pulse(stop_len);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors   = 0;
    checks   = 0;
    req      = '0;
    host_low = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check(sirq_oe == 1'b0, "R1", "oe in reset", {31'h0, sirq_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sirq_oe == 1'b0, "R1", "oe after reset", {31'h0, sirq_oe}, 32'h0);

    // R1: continuous after reset, a rising request starts nothing
    req[0] = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        seen |= sirq_oe;
      end
      check(!seen, "R1", "no self start after reset", {31'h0, seen}, 32'h0);
    end

    // table walk: R2 start lengths, R3 invalid lengths, R4 slot map
    for (int v = 0; v < 8; v++) begin
      req = VEC[v][26:20];
      frame(int'(VEC[v][19:16]), 3, VEC[v][15:0],
            (VEC[v][19:16] < 4 || VEC[v][19:16] > 8) ? "R3" : "R4");
    end

    // R6: level sampling mid-frame
    req = 7'h04;
    fork
      frame(4, 3, 16'h0200, "R6");
      begin
        repeat (11) @(negedge clk);
        req[2] = 1'b0;
        req[3] = 1'b1;
      end
    join

    // clear pending edge, then stop of 2 -> quiet (R7)
    req = '0;
    frame(4, 2, 16'h0000, "R2");
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        seen |= sirq_oe;
      end
      check(!seen, "R8", "quiet idle without new request", {31'h0, seen}, 32'h0);
    end

    // R8: self start two clocks after rise
    req[0] = 1'b1;
    @(negedge clk);
    check(sirq_oe == 1'b0, "R8", "no drive one clock after rise", {31'h0, sirq_oe}, 32'h0);
    @(negedge clk);
    check(sirq_oe == 1'b1 && line == 1'b0, "R8", "self-start low clock",
          {30'h0, sirq_oe, line}, 32'h2);
    host_low = 1'b1;
    @(negedge clk);
    check(sirq_oe == 1'b0, "R8", "pulse is one clock", {31'h0, sirq_oe}, 32'h0);
    host_pulse(3);
    capture();
    judge(16'h0002, "R7");
    host_pulse(3);
    repeat (2) @(negedge clk);

    // R7 back to continuous, R9 no self start
    req[6] = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        seen |= sirq_oe;
      end
      check(!seen, "R9", "continuous mode ignores new request", {31'h0, seen}, 32'h0);
    end
    frame(5, 3, 16'h1002, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule